// File: doc/BRIEF.md
# PCIe Error Classification and Signaling Unit

This unit takes one detected error event per handshake and decides what the event means for the function that saw it. Each event carries a one-hot status code, a flag that selects the correctable or uncorrectable class, an advisory flag, a requester source ID and a flag that says whether a header was captured. The unit first keeps only the code bits that are supported for the selected class. It then classifies the event using the reporting enables, the system-error enable, the two mask registers and a per-bit severity register. It updates sticky device, correctable and uncorrectable status vectors and requests a record from an external header log. It also decides whether an error message of a given severity goes upstream.

Messages leave through a valid/ready port as a 2-bit severity code (0 correctable, 1 non-fatal, 2 fatal) plus the source ID. If the header log reports that it had no room for a record, the unit raises a correctable header-log-overflow event of its own once the original message has gone out, and that event follows the same correctable rules. While a message or a chained event is pending, the unit does not accept a new event.

Top module: `aer_err_signal`

## Requirements
- R1: The input code is ANDed with the supported set of its class: uncorrectable bits 4, 5 and 12 to 25, correctable bits 0, 6, 7, 8, 12, 13, 14 and 15. If zero bits or more than one bit remain, the request is rejected. `rej_o` is high for the one cycle after the accepting edge, and no status bit, log request or message results.
- R2: A correctable event sets device status bit 0 and its own bit in the correctable status. A message of severity 0 is sent only when that bit is clear in the correctable mask and the correctable reporting enable is set.
- R3: The severity register resets to fatal for uncorrectable bits 4, 5, 13, 17, 18 and 22 and to non-fatal for every other uncorrectable bit. A write stores only the supported bits. An unmasked uncorrectable event is fatal exactly when its severity bit is set.
- R4: An uncorrectable event whose bit is set in the uncorrectable mask sets its uncorrectable status bit. It also sets device status bit 2 if it is fatal or bit 1 if it is non-fatal, plus bit 3 for an unsupported request (bit 20). It produces no log request and no message.
- R5: A non-fatal uncorrectable event with the advisory flag set is handled as correctable. It sets correctable bit 13, its uncorrectable status bit and device status bit 0 (plus bit 3 for an unsupported request). It is logged only when neither correctable mask bit 13 nor its uncorrectable mask bit is set. It is sent as severity 0 only when mask bit 13 is clear, the correctable enable is set and, for an unsupported request, the UR enable is set.
- R6: An unmasked fatal event is sent as severity 2 when the system-error enable or the fatal enable is set. An unmasked non-fatal event is sent as severity 1 when the system-error enable or the non-fatal enable is set. An unsupported request with neither the UR enable nor the system-error enable set sends nothing.
- R7: Every logged event raises `log_req_o` combinationally in its accepting cycle, with the filtered one-hot code and the header-valid flag.
- R8: If `log_ovf_i` is high with a log request, a correctable event on bit 15 carrying the same source ID is processed after the original message completes (or at once if none was sent). It updates status and may send a severity-0 message under R2's rules.
- R9: While a message is pending, `evt_ready_o` is low, and severity and source ID stay stable until `msg_ready_i`. Severity code 3 never appears.
- R10: Status bits are sticky. A clear vector clears the bits that are set in it, and a bit that is set and cleared in the same cycle ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_valid_i | input | 1 | Error event present |
| evt_ready_o | output | 1 | Unit idle, event accepted this cycle |
| evt_code_i | input | 32 | One-hot error status code |
| evt_uncor_i | input | 1 | 1 = uncorrectable class |
| evt_adv_i | input | 1 | Event may be advisory |
| evt_src_i | input | SRC_W | Source ID of the requester |
| evt_hdr_i | input | 1 | Header capture valid |
| rpt_cor_en_i | input | 1 | Correctable reporting enable |
| rpt_nf_en_i | input | 1 | Non-fatal reporting enable |
| rpt_fat_en_i | input | 1 | Fatal reporting enable |
| rpt_ur_en_i | input | 1 | Unsupported-request reporting enable |
| serr_en_i | input | 1 | System-error enable |
| cor_mask_i | input | 32 | Correctable mask |
| unc_mask_i | input | 32 | Uncorrectable mask |
| sev_we_i | input | 1 | Severity register write strobe |
| sev_wdata_i | input | 32 | Severity write data |
| sev_o | output | 32 | Severity register |
| cor_sts_o | output | 32 | Correctable status |
| unc_sts_o | output | 32 | Uncorrectable status |
| dev_sts_o | output | 4 | Device status: 0 correctable, 1 non-fatal, 2 fatal, 3 unsupported request |
| cor_clr_i | input | 32 | Correctable status clear vector |
| unc_clr_i | input | 32 | Uncorrectable status clear vector |
| dev_clr_i | input | 4 | Device status clear vector |
| log_req_o | output | 1 | Header log record request |
| log_code_o | output | 32 | Code of the logged error |
| log_hdr_o | output | 1 | Header valid for the record |
| log_ovf_i | input | 1 | Log had no room for the record |
| msg_valid_o | output | 1 | Error message pending |
| msg_ready_i | input | 1 | Upstream takes the message |
| msg_sev_o | output | 2 | Message severity code |
| msg_src_o | output | SRC_W | Message source ID |
| rej_o | output | 1 | Malformed request pulse |

## Verification
The bench sweeps every one of the 32 code positions in both classes, with and without the advisory flag, under all 32 combinations of the five enables. It does so with both clear and striped masks and with the default and the inverted severity map. Single unsupported bits separate the filter from the classifier. The enable sweep separates the system-error and UR rules from the plain reporting enables. Striped masks and the inverted severity map separate demotion, masking and fatal choice. A periodic overflow answer exercises the chained event with and without its own mask. Directed cases cover multi-bit codes, a code that becomes one-hot only after filtering, held backpressure and a clear that coincides with a set.

// File: rtl/aer_sig_pkg.sv
package aer_sig_pkg;
    localparam int CODE_W = 32;

    localparam logic [CODE_W-1:0] UNC_SUP     = 32'h03FF_F030;
    localparam logic [CODE_W-1:0] UNC_SEV_DEF = 32'h0046_2030;
    localparam logic [CODE_W-1:0] COR_SUP     = 32'h0000_F1C1;

    localparam int UR_BIT  = 20;
    localparam int ADV_BIT = 13;
    localparam int HLO_BIT = 15;

    localparam int DS_W   = 4;
    localparam int DS_COR = 0;
    localparam int DS_NF  = 1;
    localparam int DS_FAT = 2;
    localparam int DS_UR  = 3;

    typedef enum logic [1:0] {
        SEV_COR = 2'd0,
        SEV_NF  = 2'd1,
        SEV_FAT = 2'd2
    } sev_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SEND  = 2'd1,
        ST_CHAIN = 2'd2
    } st_e;

    typedef struct packed {
        logic              ok;
        logic [CODE_W-1:0] cor_set;
        logic [CODE_W-1:0] unc_set;
        logic [DS_W-1:0]   dev_set;
        logic              log;
        logic              send;
        sev_e              sev;
    } verdict_t;
endpackage

// File: rtl/aer_code_check.sv
module aer_code_check #(
    parameter int W = 32
) (
    input  logic [W-1:0] code_i,
    input  logic [W-1:0] sup_i,
    output logic [W-1:0] code_o,
    output logic         ok_o
);
    localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

    always_comb begin
        code_o = code_i & sup_i;
        ok_o   = (code_o != '0) && ((code_o & (code_o - ONE)) == '0);
    end
endmodule

// File: rtl/aer_classify.sv
module aer_classify
    import aer_sig_pkg::*;
(
    input  logic [CODE_W-1:0] code_i,
    input  logic              ok_i,
    input  logic              uncor_i,
    input  logic              adv_i,
    input  logic              cor_en_i,
    input  logic              nf_en_i,
    input  logic              fat_en_i,
    input  logic              ur_en_i,
    input  logic              serr_i,
    input  logic [CODE_W-1:0] cor_mask_i,
    input  logic [CODE_W-1:0] unc_mask_i,
    input  logic [CODE_W-1:0] sev_i,
    output verdict_t          v_o
);
    logic fatal, ur, unc_hit, cor_hit, adv_hit;

    always_comb begin
        fatal   = |(code_i & sev_i);
        ur      = uncor_i && code_i[UR_BIT];
        unc_hit = |(code_i & unc_mask_i);
        cor_hit = |(code_i & cor_mask_i);
        adv_hit = cor_mask_i[ADV_BIT];

        v_o     = '0;
        v_o.ok  = ok_i;
        v_o.sev = SEV_COR;
        if (ok_i) begin
            if (!uncor_i) begin
                v_o.dev_set[DS_COR] = 1'b1;
                v_o.cor_set         = code_i;
                v_o.send            = !cor_hit && cor_en_i;
            end else if (!fatal && adv_i) begin
                v_o.dev_set[DS_COR]  = 1'b1;
                v_o.dev_set[DS_UR]   = ur;
                v_o.cor_set[ADV_BIT] = 1'b1;
                v_o.unc_set          = code_i;
                v_o.log              = !adv_hit && !unc_hit;
                v_o.send             = !adv_hit && !(ur && !ur_en_i) && cor_en_i;
            end else begin
                v_o.dev_set[DS_FAT] = fatal;
                v_o.dev_set[DS_NF]  = !fatal;
                v_o.dev_set[DS_UR]  = ur;
                v_o.unc_set         = code_i;
                v_o.sev             = fatal ? SEV_FAT : SEV_NF;
                if (!unc_hit) begin
                    v_o.log  = 1'b1;
                    v_o.send = !(ur && !ur_en_i && !serr_i)
                               && (serr_i || (fatal ? fat_en_i : nf_en_i));
                end
            end
        end
    end
endmodule

// File: rtl/aer_err_signal.sv
module aer_err_signal
    import aer_sig_pkg::*;
#(
    parameter int SRC_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              evt_valid_i,
    output logic              evt_ready_o,
    input  logic [CODE_W-1:0] evt_code_i,
    input  logic              evt_uncor_i,
    input  logic              evt_adv_i,
    input  logic [SRC_W-1:0]  evt_src_i,
    input  logic              evt_hdr_i,
    input  logic              rpt_cor_en_i,
    input  logic              rpt_nf_en_i,
    input  logic              rpt_fat_en_i,
    input  logic              rpt_ur_en_i,
    input  logic              serr_en_i,
    input  logic [CODE_W-1:0] cor_mask_i,
    input  logic [CODE_W-1:0] unc_mask_i,
    input  logic              sev_we_i,
    input  logic [CODE_W-1:0] sev_wdata_i,
    output logic [CODE_W-1:0] sev_o,
    output logic [CODE_W-1:0] cor_sts_o,
    output logic [CODE_W-1:0] unc_sts_o,
    output logic [DS_W-1:0]   dev_sts_o,
    input  logic [CODE_W-1:0] cor_clr_i,
    input  logic [CODE_W-1:0] unc_clr_i,
    input  logic [DS_W-1:0]   dev_clr_i,
    output logic              log_req_o,
    output logic [CODE_W-1:0] log_code_o,
    output logic              log_hdr_o,
    input  logic              log_ovf_i,
    output logic              msg_valid_o,
    input  logic              msg_ready_i,
    output logic [1:0]        msg_sev_o,
    output logic [SRC_W-1:0]  msg_src_o,
    output logic              rej_o
);
    localparam logic [CODE_W-1:0] HLO_CODE = CODE_W'(1) << HLO_BIT;

    typedef struct packed {
        st_e               st;
        logic [CODE_W-1:0] cor_sts;
        logic [CODE_W-1:0] unc_sts;
        logic [DS_W-1:0]   dev_sts;
        logic [CODE_W-1:0] sev;
        sev_e              msg_sev;
        logic [SRC_W-1:0]  msg_src;
        logic [SRC_W-1:0]  src;
        logic              ovf;
        logic              rej;
    } state_t;

    state_t s_d, s_q;

    logic              in_chain;
    logic [CODE_W-1:0] raw_code, sup, flt_code;
    logic              code_ok, cls_uncor;
    verdict_t          vd;

    always_comb begin
        in_chain  = (s_q.st == ST_CHAIN);
        raw_code  = in_chain ? HLO_CODE : evt_code_i;
        cls_uncor = in_chain ? 1'b0 : evt_uncor_i;
        sup       = cls_uncor ? UNC_SUP : COR_SUP;
    end

    aer_code_check #(.W(CODE_W)) u_check (
        .code_i (raw_code),
        .sup_i  (sup),
        .code_o (flt_code),
        .ok_o   (code_ok)
    );

    aer_classify u_class (
        .code_i     (flt_code),
        .ok_i       (code_ok),
        .uncor_i    (cls_uncor),
        .adv_i      (in_chain ? 1'b0 : evt_adv_i),
        .cor_en_i   (rpt_cor_en_i),
        .nf_en_i    (rpt_nf_en_i),
        .fat_en_i   (rpt_fat_en_i),
        .ur_en_i    (rpt_ur_en_i),
        .serr_i     (serr_en_i),
        .cor_mask_i (cor_mask_i),
        .unc_mask_i (unc_mask_i),
        .sev_i      (s_q.sev),
        .v_o        (vd)
    );

    always_comb begin
        logic apply;
        s_d     = s_q;
        s_d.rej = 1'b0;
        apply   = 1'b0;

        if (sev_we_i) s_d.sev = sev_wdata_i & UNC_SUP;

        s_d.cor_sts = s_q.cor_sts & ~cor_clr_i;
        s_d.unc_sts = s_q.unc_sts & ~unc_clr_i;
        s_d.dev_sts = s_q.dev_sts & ~dev_clr_i;

        unique case (s_q.st)
            ST_IDLE: begin
                if (evt_valid_i) begin
                    if (!vd.ok) begin
                        s_d.rej = 1'b1;
                    end else begin
                        apply     = 1'b1;
                        s_d.src   = evt_src_i;
                        s_d.ovf   = vd.log && log_ovf_i;
                        if (vd.send) begin
                            s_d.st      = ST_SEND;
                            s_d.msg_sev = vd.sev;
                            s_d.msg_src = evt_src_i;
                        end else if (vd.log && log_ovf_i) begin
                            s_d.st  = ST_CHAIN;
                            s_d.ovf = 1'b0;
                        end
                    end
                end
            end
            ST_SEND: begin
                if (msg_ready_i) begin
                    s_d.st  = s_q.ovf ? ST_CHAIN : ST_IDLE;
                    s_d.ovf = 1'b0;
                end
            end
            ST_CHAIN: begin
                apply = 1'b1;
                if (vd.send) begin
                    s_d.st      = ST_SEND;
                    s_d.msg_sev = vd.sev;
                    s_d.msg_src = s_q.src;
                end else begin
                    s_d.st = ST_IDLE;
                end
            end
            default: s_d.st = ST_IDLE;
        endcase

        if (apply) begin
            s_d.cor_sts = s_d.cor_sts | vd.cor_set;
            s_d.unc_sts = s_d.unc_sts | vd.unc_set;
            s_d.dev_sts = s_d.dev_sts | vd.dev_set;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q         <= '0;
            s_q.st      <= ST_IDLE;
            s_q.sev     <= UNC_SEV_DEF;
            s_q.msg_sev <= SEV_COR;
        end else begin
            s_q <= s_d;
        end
    end

    always_comb begin
        evt_ready_o = (s_q.st == ST_IDLE);
        log_req_o   = evt_ready_o && evt_valid_i && vd.ok && vd.log;
        log_code_o  = flt_code;
        log_hdr_o   = evt_hdr_i;
        msg_valid_o = (s_q.st == ST_SEND);
        msg_sev_o   = s_q.msg_sev;
        msg_src_o   = s_q.msg_src;
        rej_o       = s_q.rej;
        sev_o       = s_q.sev;
        cor_sts_o   = s_q.cor_sts;
        unc_sts_o   = s_q.unc_sts;
        dev_sts_o   = s_q.dev_sts;
    end
endmodule

// File: rtl/aer_err_signal_chk.sv
module aer_err_signal_chk #(
    parameter int SRC_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             evt_valid_i,
    input logic             evt_ready_o,
    input logic             log_req_o,
    input logic             msg_valid_o,
    input logic             msg_ready_i,
    input logic [1:0]       msg_sev_o,
    input logic [SRC_W-1:0] msg_src_o,
    input logic             rej_o,
    input logic [31:0]      unc_sts_o,
    input logic [31:0]      unc_clr_i,
    input logic [31:0]      cor_sts_o,
    input logic [31:0]      cor_clr_i
);
    p_rej_after_accept_r1: assert property (@(posedge clk) disable iff (!rst_n)
        rej_o |-> ($past(evt_valid_i && evt_ready_o) && !msg_valid_o));

    p_log_only_on_accept_r7: assert property (@(posedge clk) disable iff (!rst_n)
        log_req_o |-> (evt_valid_i && evt_ready_o));

    p_msg_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_valid_o && !msg_ready_i) |=> (msg_valid_o && $stable(msg_sev_o) && $stable(msg_src_o)));

    p_busy_blocks_r9: assert property (@(posedge clk) disable iff (!rst_n)
        msg_valid_o |-> !evt_ready_o);

    p_sev_legal_r9: assert property (@(posedge clk) disable iff (!rst_n)
        msg_valid_o |-> (msg_sev_o != 2'd3));

    p_unc_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((($past(unc_sts_o) & ~unc_sts_o) & ~$past(unc_clr_i)) == 32'h0));

    p_cor_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((($past(cor_sts_o) & ~cor_sts_o) & ~$past(cor_clr_i)) == 32'h0));
endmodule

bind aer_err_signal aer_err_signal_chk #(.SRC_W(SRC_W)) u_chk (.*);

// File: tb/aer_err_signal_tb_top.sv
module aer_err_signal_tb_top;
    localparam int CLK_P = 10;
    localparam logic [31:0] T_UNC_SUP = 32'h03FF_F030;
    localparam logic [31:0] T_COR_SUP = 32'h0000_F1C1;
    localparam logic [31:0] T_SEV_DEF = 32'h0046_2030;
    localparam logic [31:0] T_SEV_INV = 32'h03B9_D000;

    logic clk = 1'b0;
    logic rst_n;
    logic evt_valid_i, evt_ready_o, evt_uncor_i, evt_adv_i, evt_hdr_i;
    logic [31:0] evt_code_i;
    logic [15:0] evt_src_i;
    logic rpt_cor_en_i, rpt_nf_en_i, rpt_fat_en_i, rpt_ur_en_i, serr_en_i;
    logic [31:0] cor_mask_i, unc_mask_i, sev_wdata_i, sev_o, cor_sts_o, unc_sts_o;
    logic [31:0] cor_clr_i, unc_clr_i, log_code_o;
    logic sev_we_i, log_req_o, log_hdr_o, log_ovf_i, msg_valid_o, msg_ready_i, rej_o;
    logic [3:0] dev_sts_o, dev_clr_i;
    logic [1:0] msg_sev_o;
    logic [15:0] msg_src_o;

    int n_chk = 0;
    int n_fail = 0;

    always #(CLK_P/2) clk = ~clk;

    aer_err_signal dut_i (.*);

    task automatic tick;
        @(negedge clk);
    endtask

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // cfg: [0] cor_en [1] nf_en [2] fat_en [3] ur_en [4] serr
    task automatic model(input logic [31:0] code, input bit unc, input bit adv, input logic [4:0] cfg,
                         input logic [31:0] cm, input logic [31:0] um, input logic [31:0] sv, input bit ovf,
                         output bit rej, output bit lg, output int nmsg, output logic [1:0] s0,
                         output logic [31:0] ecs, output logic [31:0] eus, output logic [3:0] eds);
        logic [31:0] c;
        bit fat, ur, snd;
        c = code & (unc ? T_UNC_SUP : T_COR_SUP);
        rej = 0; lg = 0; nmsg = 0; s0 = 0; ecs = 0; eus = 0; eds = 0; snd = 0;
        if (c == 0 || $countones(c) != 1) begin
            rej = 1;
            return;
        end
        ur = unc && c[20];
        fat = |(c & sv);
        if (!unc) begin
            eds[0] = 1; ecs = c;
            snd = ((c & cm) == 0) && cfg[0];
        end else if (!fat && adv) begin
            eds[0] = 1; eds[3] = ur; ecs[13] = 1; eus = c;
            lg = !cm[13] && ((c & um) == 0);
            snd = !cm[13] && !(ur && !cfg[3]) && cfg[0];
        end else begin
            eds[fat ? 2 : 1] = 1; eds[3] = ur; eus = c;
            if ((c & um) == 0) begin
                lg = 1;
                snd = !(ur && !cfg[3] && !cfg[4]) && (cfg[4] || (fat ? cfg[2] : cfg[1]));
                s0 = fat ? 2'd2 : 2'd1;
            end
        end
        if (snd) nmsg = 1;
        if (lg && ovf) begin
            ecs[15] = 1; eds[0] = 1;
            if (!cm[15] && cfg[0]) begin
                if (nmsg == 0) s0 = 2'd0;
                nmsg++;
            end
        end
    endtask

    task automatic set_cfg(input logic [4:0] cfg, input logic [31:0] cm, input logic [31:0] um, input logic [31:0] sv);
        rpt_cor_en_i = cfg[0]; rpt_nf_en_i = cfg[1]; rpt_fat_en_i = cfg[2];
        rpt_ur_en_i = cfg[3]; serr_en_i = cfg[4];
        cor_mask_i = cm; unc_mask_i = um;
        sev_we_i = 1; sev_wdata_i = sv;
        tick;
        sev_we_i = 0;
    endtask

    task automatic run_ev(input logic [31:0] code, input bit unc, input bit adv, input logic [15:0] src,
                          input bit hdr, input bit ovf, input logic [4:0] cfg,
                          input logic [31:0] cm, input logic [31:0] um, input logic [31:0] sv);
        bit e_rej, e_lg, g_lg, g_hdr, g_rej;
        int e_n, g_n;
        logic [1:0] e_s0, g_s[2];
        logic [31:0] e_cs, e_us, g_lc;
        logic [3:0] e_ds;
        bit src_ok;
        cor_clr_i = '1; unc_clr_i = '1; dev_clr_i = '1;
        tick;
        cor_clr_i = '0; unc_clr_i = '0; dev_clr_i = '0;
        evt_valid_i = 1; evt_code_i = code; evt_uncor_i = unc; evt_adv_i = adv;
        evt_src_i = src; evt_hdr_i = hdr; log_ovf_i = ovf;
        #1;
        g_lg = log_req_o; g_lc = log_code_o; g_hdr = log_hdr_o;
        tick;
        evt_valid_i = 0; log_ovf_i = 0;
        g_rej = rej_o;
        g_n = 0; src_ok = 1; g_s[0] = 0; g_s[1] = 0;
        for (int k = 0; k < 6; k++) begin
            if (msg_valid_o && msg_ready_i) begin
                if (g_n < 2) g_s[g_n] = msg_sev_o;
                if (msg_src_o != src) src_ok = 0;
                g_n++;
            end
            tick;
        end
        model(code, unc, adv, cfg, cm, um, sv, ovf, e_rej, e_lg, e_n, e_s0, e_cs, e_us, e_ds);
        chk(g_rej == e_rej, "R1 reject pulse", 64'(g_rej), 64'(e_rej));
        chk(g_lg == e_lg, "R7 log request", 64'(g_lg), 64'(e_lg));
        if (e_lg) chk(g_lc == (code & (unc ? T_UNC_SUP : T_COR_SUP)) && g_hdr == hdr,
                      "R7 log code/header", {g_lc, 31'b0, g_hdr}, {code, 31'b0, hdr});
        chk(g_n == e_n, unc ? (adv ? "R5 message count" : "R6 message count") : "R2 message count",
            64'(g_n), 64'(e_n));
        if (e_n > 0 && g_n > 0) chk(g_s[0] == e_s0, unc ? "R3 message severity" : "R2 message severity",
                                   64'(g_s[0]), 64'(e_s0));
        if (e_n == 2 && g_n == 2) chk(g_s[1] == 2'd0, "R8 chained severity", 64'(g_s[1]), 64'd0);
        chk(src_ok, "R8 message source", 64'(msg_src_o), 64'(src));
        chk(cor_sts_o == e_cs, "R2 correctable status", 64'(cor_sts_o), 64'(e_cs));
        chk(unc_sts_o == e_us, "R4 uncorrectable status", 64'(unc_sts_o), 64'(e_us));
        chk(dev_sts_o == e_ds, "R4 device status", 64'(dev_sts_o), 64'(e_ds));
    endtask

    initial begin
        #(CLK_P * 190000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        rst_n = 0; evt_valid_i = 0; evt_code_i = 0; evt_uncor_i = 0; evt_adv_i = 0;
        evt_src_i = 0; evt_hdr_i = 0; rpt_cor_en_i = 0; rpt_nf_en_i = 0; rpt_fat_en_i = 0;
        rpt_ur_en_i = 0; serr_en_i = 0; cor_mask_i = 0; unc_mask_i = 0; sev_we_i = 0;
        sev_wdata_i = 0; cor_clr_i = 0; unc_clr_i = 0; dev_clr_i = 0; log_ovf_i = 0;
        msg_ready_i = 1;
        repeat (3) tick;
        rst_n = 1;
        tick;

        // reset state
        chk(sev_o == T_SEV_DEF, "R3 severity reset default", 64'(sev_o), 64'(T_SEV_DEF));
        chk(cor_sts_o == 0 && unc_sts_o == 0 && dev_sts_o == 0, "R10 status reset",
            {cor_sts_o, unc_sts_o}, 64'd0);
        chk(evt_ready_o && !msg_valid_o && !rej_o, "R9 idle after reset",
            64'({evt_ready_o, msg_valid_o, rej_o}), 64'b100);

        // severity write keeps only supported bits
        sev_we_i = 1; sev_wdata_i = '1;
        tick;
        sev_we_i = 0;
        chk(sev_o == T_UNC_SUP, "R3 severity write filter", 64'(sev_o), 64'(T_UNC_SUP));

        // full sweep
        for (int mp = 0; mp < 2; mp++) begin
            for (int cf = 0; cf < 32; cf++) begin
                logic [31:0] cm, um, sv;
                cm = mp ? 32'hAAAA_AAAA : 32'h0;
                um = mp ? 32'h5555_5555 : 32'h0;
                sv = (cf[4] ^ mp[0]) ? T_SEV_INV : T_SEV_DEF;
                set_cfg(5'(cf), cm, um, sv);
                for (int b = 0; b < 32; b++) begin
                    logic [31:0] cd;
                    cd = 32'h1 << b;
                    run_ev(cd, 0, 0, 16'(b * 97 + cf), b[0], (b % 3) == 0, 5'(cf), cm, um, sv);
                    run_ev(cd, 1, 0, 16'(b * 31 + cf), b[0], (b % 3) == 0, 5'(cf), cm, um, sv);
                    run_ev(cd, 1, 1, 16'(b * 13 + cf), b[1], (b % 3) == 0, 5'(cf), cm, um, sv);
                end
            end
        end

        // multi-bit and filtered codes
        set_cfg(5'h1F, 32'h0, 32'h0, T_SEV_DEF);
        run_ev(32'h0030_0000, 1, 0, 16'h1234, 1, 0, 5'h1F, 32'h0, 32'h0, T_SEV_DEF); // R1 two bits
        run_ev(32'h0000_0041, 0, 0, 16'h1235, 0, 0, 5'h1F, 32'h0, 32'h0, T_SEV_DEF); // R1 two bits
        run_ev(32'h0000_0003, 0, 0, 16'h1236, 0, 0, 5'h1F, 32'h0, 32'h0, T_SEV_DEF); // R1 one after filter
        run_ev(32'h0000_0000, 1, 0, 16'h1237, 0, 0, 5'h1F, 32'h0, 32'h0, T_SEV_DEF); // R1 empty

        // backpressure R9
        msg_ready_i = 0;
        evt_valid_i = 1; evt_code_i = 32'h0000_0010; evt_uncor_i = 1; evt_adv_i = 0;
        evt_src_i = 16'hBEEF; evt_hdr_i = 0;
        tick;
        evt_valid_i = 0;
        for (int k = 0; k < 3; k++) begin
            chk(msg_valid_o && !evt_ready_o && msg_sev_o == 2'd2 && msg_src_o == 16'hBEEF,
                "R9 message held", {30'b0, msg_valid_o, evt_ready_o, 14'b0, msg_sev_o, msg_src_o},
                {30'b0, 2'b10, 14'b0, 2'd2, 16'hBEEF});
            tick;
        end
        msg_ready_i = 1;
        tick;
        chk(!msg_valid_o && evt_ready_o, "R9 release", 64'({msg_valid_o, evt_ready_o}), 64'b01);

        // set wins over clear R10
        unc_clr_i = '1;
        evt_valid_i = 1; evt_code_i = 32'h0000_1000; evt_uncor_i = 1; evt_adv_i = 0;
        tick;
        evt_valid_i = 0; unc_clr_i = 0;
        chk(unc_sts_o == 32'h0000_1000, "R10 set beats clear", 64'(unc_sts_o), 64'h1000);
        repeat (4) tick;
        unc_clr_i = 32'h0000_1000;
        tick;
        unc_clr_i = 0;
        chk(unc_sts_o == 0, "R10 clear", 64'(unc_sts_o), 64'd0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule